// File: doc/BRIEF.md
# Conditional Jump Resolver

This block settles, for a jump instruction in flight, whether the jump is taken and which address the program counter moves to next. It reads a four-bit condition selector, three condition flags (overflow, zero, negative) left by the last arithmetic or logic operation, a qualifier that says the current instruction is a jump, the absolute destination address decoded from the instruction, and the fall-through address. The fall-through address is the one just past the five-byte jump instruction. The decision and the selected address are purely combinational.

Conditions are signed comparisons formed only from the negative, overflow and zero flags. Destinations are whole absolute addresses and are never added to the current PC. An optional register stage, chosen by a parameter, captures the selected address as the program counter. It has an active-low reset and a stall input that freezes it. Selector values above 6 name no condition. A jump with such a selector is not taken, and the block flags it on a separate pin.

All pins are plain control and status pins. The block has no streaming interface and so no valid/ready back-pressure.

Top module: `jump_resolver`

## Requirements
- R1: With `is_jump`=1 and `cond_sel`=0, `taken` is 1 whatever the flags are.
- R2: With `is_jump`=1 and `cond_sel`=1 (less or equal), `taken` = (`flag_neg` != `flag_ovf`) OR `flag_zero`.
- R3: With `is_jump`=1 and `cond_sel`=2 (less), `taken` = (`flag_neg` != `flag_ovf`).
- R4: With `is_jump`=1, `cond_sel`=3 (equal) gives `taken` = `flag_zero`, and `cond_sel`=4 (not equal) gives `taken` = NOT `flag_zero`.
- R5: With `is_jump`=1, `cond_sel`=5 (greater or equal) gives `taken` = (`flag_neg` == `flag_ovf`), and `cond_sel`=6 (greater) gives `taken` = (`flag_neg` == `flag_ovf`) AND NOT `flag_zero`.
- R6: `next_pc` equals `dest_addr` when `taken` is 1. Otherwise it equals `seq_addr`, the address five bytes past the jump, which passes through unchanged. Both paths are combinational in the same cycle.
- R7: With `is_jump`=0, `taken`=0, `bad_cond`=0 and `next_pc`=`seq_addr` for any selector and any flags.
- R8: With `is_jump`=1 and `cond_sel` from 7 to 15, `taken`=0, `bad_cond`=1 and `next_pc`=`seq_addr`. `bad_cond` is 0 for selectors 0 to 6.
- R9: `pc_q` is 0 during reset. On each rising clock edge with `stall`=0, `pc_q` takes the `next_pc` value present before that edge.
- R10: On a rising edge with `stall`=1, `pc_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register |
| rst_n | input | 1 | Active-low reset of the PC register |
| stall | input | 1 | Freezes the PC register when 1 |
| is_jump | input | 1 | Current instruction is a jump |
| cond_sel | input | 4 | Jump condition selector |
| flag_ovf | input | 1 | Overflow flag |
| flag_zero | input | 1 | Zero flag |
| flag_neg | input | 1 | Negative (sign) flag |
| dest_addr | input | ADDR_W | Absolute jump destination |
| seq_addr | input | ADDR_W | Fall-through address |
| taken | output | 1 | Jump is taken |
| bad_cond | output | 1 | Jump uses an undefined selector |
| next_pc | output | ADDR_W | Selected next address (combinational) |
| pc_q | output | ADDR_W | Registered program counter |

## Verification
The assertions check these rules on every cycle:
- a non-jump is never taken or flagged and always falls through;
- a taken jump always selects the destination address;
- an undefined selector is never taken;
- selector 0 always jumps;
- the PC register either holds under stall or loads the previous selected address.

The truth of each signed condition (R2 to R5) over all eight flag combinations is shown only by the bench's sweep and random patterns. The same holds for reset behaviour and for the cycle-exact effect of stall runs.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    JC_ALWAYS = 4'd0,
    JC_LE     = 4'd1,
    JC_LT     = 4'd2,
    JC_EQ     = 4'd3,
    JC_NE     = 4'd4,
    JC_GE     = 4'd5,
    JC_GT     = 4'd6
  } jcond_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic neg;
  } flags_t;
endpackage

// File: rtl/jr_cond_eval.sv
module jr_cond_eval
  import jr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  flags_t           flags,
  output logic             cond_true,
  output logic             undefined
);
  logic lt_signed;

  assign lt_signed = flags.neg ^ flags.ovf;

  always_comb begin
    cond_true = 1'b0;
    undefined = 1'b0;
    case (sel)
      JC_ALWAYS: cond_true = 1'b1;
      JC_LE:     cond_true = lt_signed | flags.zero;
      JC_LT:     cond_true = lt_signed;
      JC_EQ:     cond_true = flags.zero;
      JC_NE:     cond_true = ~flags.zero;
      JC_GE:     cond_true = ~lt_signed;
      JC_GT:     cond_true = ~lt_signed & ~flags.zero;
      default:   undefined = 1'b1;
    endcase
  end
endmodule

// File: rtl/jr_pc_select.sv
module jr_pc_select #(
  parameter int ADDR_W = 32
) (
  input  logic              qualify,
  input  logic              cond_true,
  input  logic              undefined,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic              take,
  output logic              flag_bad,
  output logic [ADDR_W-1:0] sel_addr
);
  assign take     = qualify & cond_true & ~undefined;
  assign flag_bad = qualify & undefined;
  assign sel_addr = take ? dest_addr : seq_addr;
endmodule

// File: rtl/jr_pc_reg.sv
module jr_pc_reg #(
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [ADDR_W-1:0] pc_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pc_r <= '0;
        else if (!hold) pc_r <= d;
      end
      assign q = pc_r;
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter bit REG_PC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              is_jump,
  input  logic [3:0]        cond_sel,
  input  logic              flag_ovf,
  input  logic              flag_zero,
  input  logic              flag_neg,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic              taken,
  output logic              bad_cond,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] pc_q
);
  flags_t flags;
  logic   cond_true;
  logic   undefined;

  assign flags = '{ovf: flag_ovf, zero: flag_zero, neg: flag_neg};

  jr_cond_eval u_cond (
    .sel       (cond_sel),
    .flags     (flags),
    .cond_true (cond_true),
    .undefined (undefined)
  );

  jr_pc_select #(.ADDR_W(ADDR_W)) u_sel (
    .qualify   (is_jump),
    .cond_true (cond_true),
    .undefined (undefined),
    .dest_addr (dest_addr),
    .seq_addr  (seq_addr),
    .take      (taken),
    .flag_bad  (bad_cond),
    .sel_addr  (next_pc)
  );

  jr_pc_reg #(.ADDR_W(ADDR_W), .REG_OUT(REG_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stall),
    .d     (next_pc),
    .q     (pc_q)
  );
endmodule

// File: rtl/jump_resolver_chk.sv
module jump_resolver_chk #(
  parameter int ADDR_W = 32,
  parameter bit REG_PC = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              is_jump,
  input logic [3:0]        cond_sel,
  input logic [ADDR_W-1:0] dest_addr,
  input logic [ADDR_W-1:0] seq_addr,
  input logic              taken,
  input logic              bad_cond,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] pc_q
);
  AST_IDLE_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !is_jump |-> (!taken && !bad_cond && next_pc == seq_addr)); // R7

  AST_TAKEN_USES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> next_pc == dest_addr); // R6

  AST_NOT_TAKEN_USES_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> next_pc == seq_addr); // R6

  AST_BAD_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && cond_sel > 4'd6) |-> (bad_cond && !taken)); // R8

  AST_ALWAYS_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && cond_sel == 4'd0) |-> taken); // R1

  generate
    if (REG_PC) begin : g_regchk
      AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> pc_q == $past(pc_q)); // R10

      AST_PC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> pc_q == $past(next_pc)); // R9
    end
  endgenerate
endmodule

bind jump_resolver jump_resolver_chk #(.ADDR_W(ADDR_W), .REG_PC(REG_PC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .is_jump   (is_jump),
  .cond_sel  (cond_sel),
  .dest_addr (dest_addr),
  .seq_addr  (seq_addr),
  .taken     (taken),
  .bad_cond  (bad_cond),
  .next_pc   (next_pc),
  .pc_q      (pc_q)
);

// File: tb/test_jump_resolver.sv
`timescale 1ns/1ps
module test_jump_resolver;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          is_jump = 1'b0;
  logic [3:0]    cond_sel = '0;
  logic          f_ovf = 1'b0, f_zero = 1'b0, f_neg = 1'b0;
  logic [AW-1:0] dest = '0, seq = '0;
  logic          taken, bad_cond;
  logic [AW-1:0] next_pc, pc_q;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] model_pc = '0;
  logic [AW-1:0] pend_pc = '0;

  always #4 clk = ~clk;

  jump_resolver #(.ADDR_W(AW)) i_jump_resolver (
    .clk(clk), .rst_n(rst_n), .stall(stall), .is_jump(is_jump),
    .cond_sel(cond_sel), .flag_ovf(f_ovf), .flag_zero(f_zero), .flag_neg(f_neg),
    .dest_addr(dest), .seq_addr(seq), .taken(taken), .bad_cond(bad_cond),
    .next_pc(next_pc), .pc_q(pc_q)
  );

  function automatic logic exp_take(input logic j, input logic [3:0] s,
                                    input logic o, input logic z, input logic n);
    if (!j) return 1'b0;
    case (s)
      4'd0: return 1'b1;
      4'd1: return (n != o) || z;
      4'd2: return n != o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return n == o;
      4'd6: return (n == o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic j, input logic [3:0] s);
    if (!j) return "R7";
    case (s)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: check register, drive inputs, check combinational outputs
  task automatic cycle(input logic j, input logic [3:0] s, input logic o, input logic z,
                       input logic n, input logic st, input logic [AW-1:0] d,
                       input logic [AW-1:0] q);
    logic et;
    @(negedge clk);
    model_pc = pend_pc;
    chk(st ? "R10" : "R9", "pc_q", pc_q, model_pc);
    is_jump = j; cond_sel = s; f_ovf = o; f_zero = z; f_neg = n;
    stall = st; dest = d; seq = q;
    #1;
    et = exp_take(j, s, o, z, n);
    chk(req_of(j, s), "taken", {31'd0, taken}, {31'd0, et});
    chk("R8", "bad_cond", {31'd0, bad_cond}, {31'd0, j && (s > 4'd6)});
    chk("R6", "next_pc", next_pc, et ? d : q);
    pend_pc = st ? model_pc : (et ? d : q);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "pc_q in reset", pc_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    model_pc = '0; pend_pc = '0;
    // directed sweep: every selector with every flag combination
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 8; f++)
        cycle(1'b1, 4'(s), f[2], f[1], f[0], 1'b0, 32'h1000_0000 + 32'(s * 16 + f),
              32'h0000_0400 + 32'(s * 8 + f) * 5);
    // non-jump with every selector, flags all set
    for (int s = 0; s < 16; s++)
      cycle(1'b0, 4'(s), 1'b1, 1'b1, 1'b1, 1'b0, 32'hdead_0000, 32'h0000_0105);
    // stall run: PC must hold R10 while a taken jump is presented
    cycle(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_abcd, 32'h0000_0005);
    for (int k = 0; k < 4; k++)
      cycle(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h5555_0000 + 32'(k), 32'h0000_0010);
    cycle(1'b1, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_7777, 32'h0000_0020);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[0] | r[1], r[7:4], r[8], r[9], r[10], (r[13:11] == 3'd0),
            $urandom, $urandom);
    end
    cycle(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule